// File: doc/BRIEF.md
# Dual-Timer Peripheral with Interrupts

This block is a byte-wide register-mapped unit holding two 16-bit down-counters, an interrupt flag register, an interrupt enable register and a single active-high interrupt line. A host reaches it through a 4-bit address, an 8-bit write bus with a write strobe, and an 8-bit read bus with a read strobe. The read bus always shows the addressed register. The read strobe only marks the cycle in which a read's side effects take place.

The first timer has a full 16-bit reload latch. It runs either once per start or continuously, reloading from its latch at each expiry. The second timer always runs once per start and keeps only a low-byte latch. Two byte ports and their direction registers are held as plain storage. Port B is also driven onto output pins, masked by its direction bits. The shift, auxiliary and peripheral control locations are storage only. The one exception is the timer-1 run-mode bit in the auxiliary register.

Top module: `dual_timer_unit`

## Requirements
- R1: After reset every register, counter, flag and enable is zero, both timers are disarmed, `irq_o` is 0, the enable register reads 0x80 and the flag register reads 0x00.
- R2: Addresses 0, 1, 2, 3, 10, 11 and 12 read back the last byte written to them. Address 15 is a second access path to the port A output register held at address 1.
- R3: `pb_pins_o` equals the port B output register (address 0) ANDed with the port B direction register (address 2). `pb_oe_o` equals the direction register.
- R4: Writing address 4 only stores the timer-1 latch low byte. Writing address 5 stores the latch high byte, loads the counter with {data, latch low}, and arms timer 1. Addresses 6 and 7 read and write the latch low and high bytes without starting a count. Reads of 4 and 5 return the counter's low and high bytes.
- R5: A timer loaded with value N sets its flag exactly N+2 clock edges after the edge that captured the starting write.
- R6: When auxiliary bit 6 is 0, timer 1 sets its flag once per start. Its counter still passes 0x0000 → 0xFFFF → 0xFFFE and keeps counting down, and it raises no further flag until it is restarted.
- R7: When auxiliary bit 6 is 1, timer 1 reloads its counter from the latch at each expiry and sets its flag every N+2 cycles.
- R8: Writing address 8 stores a timer-2 low latch only. Writing address 9 loads the timer-2 counter with {data, low latch} and arms it. Timer 2 is always once per start. Its flag is bit 5. Reads of 8 and 9 return its counter bytes.
- R9: Flag bit 6 is cleared by a strobed read of address 4 or a write of address 5. Flag bit 5 is cleared by a strobed read of address 8 or a write of address 9.
- R10: A write to the flag register (address 13) clears every flag bit 6..0 whose data bit is 1. A flag-register read returns bit 7 as 1 exactly when some flag bit and its enable bit are both set.
- R11: A write to the enable register (address 14) with data bit 7 = 1 sets the enables selected by bits 6..0, and with bit 7 = 0 clears them. A read returns bit 7 as 1.
- R12: `irq_o` equals bit 7 of the flag register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Write data |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| rd_en_i | input | 1 | Read strobe; marks the cycle of read side effects |
| rdata_o | output | 8 | Contents of the addressed register |
| irq_o | output | 1 | Active-high interrupt request |
| pb_pins_o | output | 8 | Port B pin value (output register masked by direction) |
| pb_oe_o | output | 8 | Port B per-pin drive enable |

## Verification
Random start values from 0 to 40 go to either timer in random order. Each run checks the flag edge to the exact cycle, which tells an N+1 or N+3 period apart from N+2 and confirms that a zero load still takes two cycles. Directed sequences cover free-running reload against a one-shot run that is held for more than 65,536 cycles: only a one-shot that re-fired after wrapping would be caught by the long hold. Random port and direction pairs separate masked pin output from plain register storage. Flag and enable patterns with mismatched bits separate the combined request bit from the raw flag bits.

// File: rtl/dtu_pkg.sv
package dtu_pkg;

    typedef enum logic [3:0] {
        A_PB_OUT    = 4'd0,
        A_PA_OUT    = 4'd1,
        A_PB_DIR    = 4'd2,
        A_PA_DIR    = 4'd3,
        A_T1_CNT_LO = 4'd4,
        A_T1_CNT_HI = 4'd5,
        A_T1_LAT_LO = 4'd6,
        A_T1_LAT_HI = 4'd7,
        A_T2_LO     = 4'd8,
        A_T2_HI     = 4'd9,
        A_SHIFT     = 4'd10,
        A_AUX       = 4'd11,
        A_PERIPH    = 4'd12,
        A_FLAGS     = 4'd13,
        A_ENABLE    = 4'd14,
        A_PA_RAW    = 4'd15
    } reg_addr_e;

    localparam int FLAG_T1     = 6;
    localparam int FLAG_T2     = 5;
    localparam int AUX_FREERUN = 6;

endpackage

// File: rtl/dtu_timer_core.sv
module dtu_timer_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] start_val_i,
    input  logic [CNT_W-1:0] reload_val_i,
    input  logic             freerun_i,
    output logic [CNT_W-1:0] count_o,
    output logic             expire_o
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             armed;
        logic             pend;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        expire_o = 1'b0;
        if (start_i) begin
            st_d.cnt   = start_val_i;
            st_d.armed = 1'b1;
            st_d.pend  = 1'b0;
        end else if (st_q.pend) begin
            // counter sits at all-ones this cycle: expiry edge
            st_d.pend = 1'b0;
            expire_o  = st_q.armed;
            if (freerun_i && st_q.armed) begin
                st_d.cnt = reload_val_i;
            end else begin
                st_d.cnt = st_q.cnt - ONE;
            end
            if (!freerun_i) begin
                st_d.armed = 1'b0;
            end
        end else begin
            st_d.cnt  = st_q.cnt - ONE;
            st_d.pend = st_q.armed && (st_q.cnt == '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o = st_q.cnt;

    // R4
    load_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (count_o == $past(start_val_i)));

    // R5
    expire_after_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |-> (count_o == '1));

    // R6
    oneshot_wraps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_o && !freerun_i) |=> (count_o == {{(CNT_W-1){1'b1}}, 1'b0}));

    // R7
    freerun_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_o && freerun_i) |=> (count_o == $past(reload_val_i)));

endmodule

// File: rtl/dtu_irq_ctrl.sv
module dtu_irq_ctrl #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-2:0] set_i,
    input  logic [DATA_W-2:0] clr_i,
    input  logic              en_wr_i,
    input  logic [DATA_W-1:0] en_wdata_i,
    output logic [DATA_W-2:0] flags_o,
    output logic [DATA_W-2:0] enables_o,
    output logic              irq_o
);

    localparam int FLAG_W = DATA_W - 1;

    typedef struct packed {
        logic [FLAG_W-1:0] flags;
        logic [FLAG_W-1:0] en;
        logic              irq;
    } irq_t;

    irq_t ic_d, ic_q;

    always_comb begin
        ic_d       = ic_q;
        // a new event in the same cycle outranks a clear
        ic_d.flags = (ic_q.flags & ~clr_i) | set_i;
        if (en_wr_i) begin
            if (en_wdata_i[DATA_W-1]) begin
                ic_d.en = ic_q.en | en_wdata_i[FLAG_W-1:0];
            end else begin
                ic_d.en = ic_q.en & ~en_wdata_i[FLAG_W-1:0];
            end
        end
        ic_d.irq = |(ic_d.flags & ic_d.en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ic_q <= '0;
        end else begin
            ic_q <= ic_d;
        end
    end

    assign flags_o   = ic_q.flags;
    assign enables_o = ic_q.en;
    assign irq_o     = ic_q.irq;

    // R10
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_i & ~set_i) != '0) |=> ((flags_o & $past(clr_i & ~set_i)) == '0));

    // R11
    enable_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_wr_i && en_wdata_i[DATA_W-1]) |=>
        ((enables_o & $past(en_wdata_i[FLAG_W-1:0])) == $past(en_wdata_i[FLAG_W-1:0])));

    // R12
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ((flags_o & enables_o) != '0));

endmodule

// File: rtl/dual_timer_unit.sv
module dual_timer_unit
    import dtu_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_o,
    output logic [DATA_W-1:0] pb_pins_o,
    output logic [DATA_W-1:0] pb_oe_o
);

    localparam int CNT_W  = 2 * DATA_W;
    localparam int FLAG_W = DATA_W - 1;

    typedef struct packed {
        logic [DATA_W-1:0] orb;
        logic [DATA_W-1:0] ora;
        logic [DATA_W-1:0] ddrb;
        logic [DATA_W-1:0] ddra;
        logic [CNT_W-1:0]  t1_lat;
        logic [DATA_W-1:0] t2_lo;
        logic [DATA_W-1:0] shift;
        logic [DATA_W-1:0] aux;
        logic [DATA_W-1:0] periph;
    } regs_t;

    regs_t rg_d, rg_q;

    reg_addr_e         sel;
    logic              wr_hit_t1_hi, wr_hit_t2_hi;
    logic [CNT_W-1:0]  t1_count, t2_count;
    logic              t1_expire, t2_expire;
    logic [FLAG_W-1:0] flag_set, flag_clr, flags, enables;
    logic              irq_int;

    assign sel          = reg_addr_e'(addr_i);
    assign wr_hit_t1_hi = wr_en_i && (sel == A_T1_CNT_HI);
    assign wr_hit_t2_hi = wr_en_i && (sel == A_T2_HI);

    // register-file next state
    always_comb begin
        rg_d = rg_q;
        if (wr_en_i) begin
            case (sel)
                A_PB_OUT:              rg_d.orb                  = wdata_i;
                A_PA_OUT, A_PA_RAW:    rg_d.ora                  = wdata_i;
                A_PB_DIR:              rg_d.ddrb                 = wdata_i;
                A_PA_DIR:              rg_d.ddra                 = wdata_i;
                A_T1_CNT_LO,
                A_T1_LAT_LO:           rg_d.t1_lat[DATA_W-1:0]   = wdata_i;
                A_T1_CNT_HI,
                A_T1_LAT_HI:           rg_d.t1_lat[CNT_W-1:DATA_W] = wdata_i;
                A_T2_LO:               rg_d.t2_lo                = wdata_i;
                A_SHIFT:               rg_d.shift                = wdata_i;
                A_AUX:                 rg_d.aux                  = wdata_i;
                A_PERIPH:              rg_d.periph               = wdata_i;
                default:               ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rg_q <= '0;
        end else begin
            rg_q <= rg_d;
        end
    end

    // flag event vectors
    always_comb begin
        flag_set          = '0;
        flag_set[FLAG_T1] = t1_expire;
        flag_set[FLAG_T2] = t2_expire;
        flag_clr          = '0;
        if (wr_en_i && (sel == A_FLAGS)) begin
            flag_clr = wdata_i[FLAG_W-1:0];
        end
        if (wr_hit_t1_hi || (rd_en_i && (sel == A_T1_CNT_LO))) begin
            flag_clr[FLAG_T1] = 1'b1;
        end
        if (wr_hit_t2_hi || (rd_en_i && (sel == A_T2_LO))) begin
            flag_clr[FLAG_T2] = 1'b1;
        end
    end

    dtu_timer_core #(.CNT_W(CNT_W)) t1_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (wr_hit_t1_hi),
        .start_val_i  ({wdata_i, rg_q.t1_lat[DATA_W-1:0]}),
        .reload_val_i (rg_q.t1_lat),
        .freerun_i    (rg_q.aux[AUX_FREERUN]),
        .count_o      (t1_count),
        .expire_o     (t1_expire)
    );

    dtu_timer_core #(.CNT_W(CNT_W)) t2_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (wr_hit_t2_hi),
        .start_val_i  ({wdata_i, rg_q.t2_lo}),
        .reload_val_i ({CNT_W{1'b0}}),
        .freerun_i    (1'b0),
        .count_o      (t2_count),
        .expire_o     (t2_expire)
    );

    dtu_irq_ctrl #(.DATA_W(DATA_W)) irq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (flag_set),
        .clr_i      (flag_clr),
        .en_wr_i    (wr_en_i && (sel == A_ENABLE)),
        .en_wdata_i (wdata_i),
        .flags_o    (flags),
        .enables_o  (enables),
        .irq_o      (irq_int)
    );

    // read mux
    always_comb begin
        case (sel)
            A_PB_OUT:           rdata_o = rg_q.orb;
            A_PA_OUT, A_PA_RAW: rdata_o = rg_q.ora;
            A_PB_DIR:           rdata_o = rg_q.ddrb;
            A_PA_DIR:           rdata_o = rg_q.ddra;
            A_T1_CNT_LO:        rdata_o = t1_count[DATA_W-1:0];
            A_T1_CNT_HI:        rdata_o = t1_count[CNT_W-1:DATA_W];
            A_T1_LAT_LO:        rdata_o = rg_q.t1_lat[DATA_W-1:0];
            A_T1_LAT_HI:        rdata_o = rg_q.t1_lat[CNT_W-1:DATA_W];
            A_T2_LO:            rdata_o = t2_count[DATA_W-1:0];
            A_T2_HI:            rdata_o = t2_count[CNT_W-1:DATA_W];
            A_SHIFT:            rdata_o = rg_q.shift;
            A_AUX:              rdata_o = rg_q.aux;
            A_PERIPH:           rdata_o = rg_q.periph;
            A_FLAGS:            rdata_o = {irq_int, flags};
            A_ENABLE:           rdata_o = {1'b1, enables};
            default:            rdata_o = '0;
        endcase
    end

    assign irq_o     = irq_int;
    assign pb_pins_o = rg_q.orb & rg_q.ddrb;
    assign pb_oe_o   = rg_q.ddrb;

    // R3
    pins_follow_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && (sel == A_PB_OUT)) |=> (pb_pins_o == ($past(wdata_i) & pb_oe_o)));

    // R8
    t2_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit_t2_hi |=> (t2_count == {$past(wdata_i), $past(rg_q.t2_lo)}));

    // R9
    t1_restart_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit_t1_hi |=> !flags[FLAG_T1]);

endmodule

// File: tb/dual_timer_unit_tb_top.sv
`timescale 1ns/1ps
module dual_timer_unit_tb_top;

    localparam logic [3:0] PB = 4'd0, PA = 4'd1, PBD = 4'd2, PAD = 4'd3;
    localparam logic [3:0] T1L = 4'd4, T1H = 4'd5, L1L = 4'd6, L1H = 4'd7;
    localparam logic [3:0] T2L = 4'd8, T2H = 4'd9, SHF = 4'd10, AUX = 4'd11;
    localparam logic [3:0] PER = 4'd12, FLG = 4'd13, ENA = 4'd14, PAR = 4'd15;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] rdata, pb_pins, pb_oe;
    logic       irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dual_timer_unit dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_i    (addr),
        .wdata_i   (wdata),
        .wr_en_i   (wr_en),
        .rd_en_i   (rd_en),
        .rdata_o   (rdata),
        .irq_o     (irq),
        .pb_pins_o (pb_pins),
        .pb_oe_o   (pb_oe)
    );

    function automatic logic [7:0] exp_pins(input logic [7:0] o, input logic [7:0] d);
        return o & d;
    endfunction

    function automatic logic [7:0] exp_flags_read(input logic [6:0] f, input logic [6:0] e);
        return {|(f & e), f};
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #0.2 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic peek(input logic [3:0] a, output logic [7:0] d);
        addr = a;
        #0.2 d = rdata;
    endtask

    task automatic expect_fire(input int n, input string req);
        repeat (n + 1) @(posedge clk);
        @(negedge clk);
        chk(req, "irq one cycle before expiry", irq, 0);
        @(posedge clk);
        @(negedge clk);
        chk(req, "irq at expiry", irq, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [7:0] shadow [16];
        void'($urandom(32'd20240611));

        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1", "irq after reset", irq, 0);
        chk("R1", "pins after reset", pb_pins, 0);
        rd(ENA, v); chk("R1", "enable read", v, 8'h80);
        rd(FLG, v); chk("R1", "flag read", v, 8'h00);
        rd(AUX, v); chk("R1", "aux read", v, 8'h00);

        // R2 plain storage, random
        for (int i = 0; i < 16; i++) shadow[i] = 8'h00;
        for (int i = 0; i < 20; i++) begin
            logic [3:0] a;
            logic [7:0] d;
            case ($urandom_range(0, 7))
                0: a = PB; 1: a = PA; 2: a = PBD; 3: a = PAD;
                4: a = SHF; 5: a = AUX; 6: a = PER; default: a = PAR;
            endcase
            d = 8'($urandom);
            wr(a, d);
            if (a == PAR) shadow[PA] = d; else shadow[a] = d;
            rd(a == PAR ? PA : a, v);
            chk("R2", "readback", v, d);
        end
        wr(PAR, 8'h5C); rd(PA, v); chk("R2", "alias 15 to 1", v, 8'h5C);
        wr(AUX, 8'h00);

        // R3 port B masking, random
        for (int i = 0; i < 10; i++) begin
            logic [7:0] o, d;
            o = 8'($urandom); d = 8'($urandom);
            wr(PBD, d); wr(PB, o);
            @(negedge clk);
            chk("R3", "pins", pb_pins, exp_pins(o, d));
            chk("R3", "oe", pb_oe, d);
        end

        // R11 enable register
        wr(ENA, 8'hE0); rd(ENA, v); chk("R11", "set 6,5", v, 8'hE0);
        wr(ENA, 8'h40); rd(ENA, v); chk("R11", "clear 6", v, 8'hA0);
        wr(ENA, 8'h7F); rd(ENA, v); chk("R11", "clear all", v, 8'h80);
        wr(ENA, 8'hE0);

        // R5 / R4 / R8 random starts on either timer
        for (int i = 0; i < 10; i++) begin
            int n;
            bit use_t1;
            n = $urandom_range(0, 40);
            if (i == 0) n = 0;
            use_t1 = ($urandom_range(0, 1) == 1);
            if (use_t1) begin
                wr(T1L, 8'(n)); wr(T1H, 8'(n >> 8));
                peek(T1H, v); chk("R4", "t1 count hi after load", v, 8'(n >> 8));
                peek(T1L, v); chk("R4", "t1 count lo after load", v, 8'(n));
                expect_fire(n, "R5");
            end else begin
                wr(T2L, 8'(n)); wr(T2H, 8'(n >> 8));
                peek(T2H, v); chk("R8", "t2 count hi after load", v, 8'(n >> 8));
                peek(T2L, v); chk("R8", "t2 count lo after load", v, 8'(n));
                expect_fire(n, "R8");
            end
            wr(FLG, 8'h60);
            chk("R10", "irq after flag clear", irq, 0);
        end

        // R7 free-running reload
        wr(AUX, 8'h40);
        wr(L1L, 8'h05); wr(T1H, 8'h00);
        expect_fire(5, "R7");
        peek(T1L, v); chk("R7", "reloaded count lo", v, 8'h05);
        addr = FLG; wdata = 8'h40; wr_en = 1'b1;
        @(posedge clk); @(negedge clk); wr_en = 1'b0;
        chk("R10", "irq after clear in free run", irq, 0);
        repeat (5) @(posedge clk);
        @(negedge clk); chk("R7", "irq before second expiry", irq, 0);
        @(posedge clk); @(negedge clk); chk("R7", "irq at second expiry", irq, 1);
        wr(AUX, 8'h00);

        // R9 write to 5 clears flag bit 6 and restarts
        wr(L1L, 8'hFF); wr(T1H, 8'h7F);
        @(negedge clk);
        chk("R9", "irq after t1 restart", irq, 0);

        // R6 one-shot: fires once, then wraps without firing
        wr(L1L, 8'h03); wr(T1H, 8'h00);
        expect_fire(3, "R6");
        peek(T1H, v); chk("R6", "count hi after one-shot expiry", v, 8'hFF);
        peek(T1L, v); chk("R6", "count lo after one-shot expiry", v, 8'hFE);
        rd(T1L, v);
        @(negedge clk);
        chk("R9", "irq after read of address 4", irq, 0);
        begin
            int highs = 0;
            for (int k = 0; k < 70000; k++) begin
                @(negedge clk);
                if (irq) highs++;
            end
            chk("R6", "irq highs across counter wrap", highs, 0);
        end

        // R4 latch access via 6/7 does not start
        wr(L1L, 8'h02); wr(L1H, 8'h00);
        repeat (20) @(negedge clk);
        rd(FLG, v); chk("R4", "no flag from latch writes", v, 8'h00);
        rd(L1L, v); chk("R4", "latch lo read", v, 8'h02);
        rd(L1H, v); chk("R4", "latch hi read", v, 8'h00);

        // R10 / R12 combined bit with mixed flags and enables
        wr(L1L, 8'h02); wr(T1H, 8'h00);
        wr(T2L, 8'h02); wr(T2H, 8'h00);
        repeat (8) @(negedge clk);
        rd(FLG, v); chk("R10", "both flags enabled", v, exp_flags_read(7'h60, 7'h60));
        chk("R12", "irq with both", irq, 1);
        wr(ENA, 8'h20);
        rd(FLG, v); chk("R10", "flags, only t1 enabled", v, exp_flags_read(7'h60, 7'h40));
        wr(FLG, 8'h40);
        rd(FLG, v); chk("R10", "t2 flag without enable", v, exp_flags_read(7'h20, 7'h40));
        chk("R12", "irq with no enabled flag", irq, 0);
        wr(ENA, 8'hA0);
        @(negedge clk);
        chk("R12", "irq once t2 enabled", irq, 1);
        rd(T2L, v);
        rd(FLG, v); chk("R9", "read of address 8 clears bit 5", v, 8'h00);
        chk("R12", "irq after t2 clear", irq, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule